// File: doc/BRIEF.md
# Cell Feature Block Normalizer

This block turns one cell of an oriented-gradient feature map into its normalized descriptor. It receives the nine 9-bin histograms of a 3×3 cell neighbourhood in a single start cycle. It forms the four 2×2-cell groups that share the centre cell and measures each group's energy as a sum of squares. It takes the truncated integer square root of each energy, and divides every centre bin by that root. The result is 36 fractional values: nine bins for each of the four groups.

The energies of all four groups are computed and captured in the start cycle, together with the centre bins. The inputs may then change freely. A single iterative square-root unit then serves the groups one after another. For each group, nine bit-serial dividers work in parallel and produce 9-bit fractions. A one-cycle done pulse marks the moment all 36 values are in place. Neighbours that fall outside the frame are expected to be driven as zero histograms.

Top module: `hog_blknorm`

## Requirements
- R1: After reset, busy, done and feat are all zero. A start pulse while busy is low captures the inputs, and busy is high from the next cycle.
- R2: Histogram bin b of cell c sits at hist[(c*9+b)*14 +: 14], where c = row*3+col and row 0 is the top row. Cell 4 is the centre. Group 0 is cells {0,1,3,4}, group 1 is {1,2,4,5}, group 2 is {3,4,6,7} and group 3 is {4,5,7,8}.
- R3: A group's energy is the sum of the squares of all 36 bins of its four cells. It is clamped to 2^26-1 when the sum exceeds that value.
- R4: A group's norm is floor(sqrt(energy)), truncated and never rounded.
- R5: When the norm is nonzero and the centre bin is smaller than the norm, the output value is floor(bin*512/norm).
- R6: When the norm is nonzero and the centre bin is greater than or equal to the norm, the output value is 511.
- R7: When a group's energy is zero, all nine of its output values are 0.
- R8: Output value for group g, bin b sits at feat[(g*9+b)*9 +: 9].
- R9: done is high for exactly one cycle per accepted start, and busy falls in that same cycle. feat holds its value from done until the next accepted start.
- R10: A start pulse while busy is high is ignored. The result belongs to the inputs captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to normalize the presented neighbourhood |
| hist | input | 1134 | Nine cell histograms, 9 bins × 14 bits each |
| busy | output | 1 | High while a normalization is in progress |
| done | output | 1 | One-cycle pulse when all 36 outputs are valid |
| feat | output | 324 | Normalized feature, 36 values × 9 fraction bits |

## Verification
Random neighbourhoods with moderate bin values keep the energies below the clamp. These exercise the fraction quotient, the group membership and the output placement: a single misplaced cell index or slot changes a norm or moves a value. Random full-range bins drive every energy into the clamp and show whether the 26-bit limit is applied. Directed patterns cover the remaining cases. One has a lone centre bin, which makes the bin equal the norm and must saturate. One has an energy of 15, which separates a truncated root from a rounded one. One has an empty corner of the frame, where a zero energy must give zero rather than a saturated value. Two further sequences check that the result is held after done, and that a second start sent mid-run changes nothing.

// File: rtl/hnorm_pkg.sv
package hnorm_pkg;
  localparam int GRID   = 3;
  localparam int NCELLS = GRID * GRID;
  localparam int CTR    = NCELLS / 2;
  localparam int NBINS  = 9;
  localparam int NBLK   = 4;
  localparam int BLK_W  = $clog2(NBLK);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_ROOT, ST_DIV} hn_state_e;

  // cell index of member k (0..3) of group g (0..3), raster order inside the group
  function automatic int cell_of(input int g, input int k);
    return ((g / 2) + (k / 2)) * GRID + (g % 2) + (k % 2);
  endfunction
endpackage

// File: rtl/hogn_energy.sv
module hogn_energy
  import hnorm_pkg::*;
#(
  parameter int BIN_W    = 14,
  parameter int ENERGY_W = 26
) (
  input  logic [NCELLS*NBINS*BIN_W-1:0] hist,
  output logic [NBLK*ENERGY_W-1:0]      energy
);
  localparam int SQ_W   = 2 * BIN_W;
  localparam int SUM_W  = SQ_W + $clog2(NBINS) + 1;
  localparam int BSUM_W = SUM_W + BLK_W;

  logic [SUM_W-1:0] csum [NCELLS];

  always_comb begin
    for (int c = 0; c < NCELLS; c++) begin
      csum[c] = '0;
      for (int b = 0; b < NBINS; b++) begin
        logic [SQ_W-1:0] wide;
        wide = {{BIN_W{1'b0}}, hist[(c*NBINS+b)*BIN_W +: BIN_W]};
        csum[c] = csum[c] + {{(SUM_W-SQ_W){1'b0}}, SQ_W'(wide * wide)};
      end
    end
  end

  always_comb begin
    for (int g = 0; g < NBLK; g++) begin
      logic [BSUM_W-1:0] bsum;
      bsum = '0;
      for (int k = 0; k < 4; k++)
        bsum = bsum + {{BLK_W{1'b0}}, csum[cell_of(g, k)]};
      if (bsum > {{(BSUM_W-ENERGY_W){1'b0}}, {ENERGY_W{1'b1}}})
        energy[g*ENERGY_W +: ENERGY_W] = '1;
      else
        energy[g*ENERGY_W +: ENERGY_W] = bsum[ENERGY_W-1:0];
    end
  end
endmodule

// File: rtl/hogn_isqrt.sv
module hogn_isqrt #(
  parameter int IN_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [IN_W-1:0]   rad,
  output logic [IN_W/2-1:0] root,
  output logic              rdy
);
  localparam int OUT_W = IN_W / 2;
  localparam int R_W   = OUT_W + 4;
  localparam int CNT_W = $clog2(OUT_W);

  logic [IN_W-1:0]  rad_q,  rad_n;
  logic [R_W-1:0]   rem_q,  rem_n;
  logic [OUT_W-1:0] root_q, root_n;
  logic [CNT_W-1:0] cnt_q,  cnt_n;
  logic             run_q,  run_n;
  logic             rdy_q,  rdy_n;
  logic             en;
  logic [R_W-1:0]   shifted, step;

  always_comb begin
    shifted = {rem_q[R_W-3:0], rad_q[IN_W-1 -: 2]};
    if (rem_q[R_W-1])
      step = shifted + {2'b00, root_q, 2'b11};
    else
      step = shifted - {2'b00, root_q, 2'b01};

    rad_n  = rad_q;
    rem_n  = rem_q;
    root_n = root_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    rdy_n  = 1'b0;
    if (go) begin
      rad_n  = rad;
      rem_n  = '0;
      root_n = '0;
      cnt_n  = CNT_W'(OUT_W - 1);
      run_n  = 1'b1;
    end else if (run_q) begin
      rad_n  = {rad_q[IN_W-3:0], 2'b00};
      rem_n  = step;
      root_n = {root_q[OUT_W-2:0], ~step[R_W-1]};
      if (cnt_q == '0) begin
        run_n = 1'b0;
        rdy_n = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  assign en = go | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_n;
      if (en) begin
        rad_q  <= rad_n;
        rem_q  <= rem_n;
        root_q <= root_n;
        cnt_q  <= cnt_n;
        run_q  <= run_n;
      end
    end
  end

  assign root = root_q;
  assign rdy  = rdy_q;
endmodule

// File: rtl/hogn_fdiv.sv
module hogn_fdiv #(
  parameter int NUM_W = 14,
  parameter int DEN_W = 13,
  parameter int Q_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [Q_W-1:0]   quo,
  output logic             rdy
);
  localparam int REM_W = DEN_W + 1;
  localparam int CNT_W = $clog2(Q_W);

  logic [DEN_W-1:0] den_q,  den_n;
  logic [REM_W-1:0] rem_q,  rem_n;
  logic [Q_W-1:0]   q_q,    q_n;
  logic [Q_W-1:0]   quo_q,  quo_n;
  logic [CNT_W-1:0] cnt_q,  cnt_n;
  logic             run_q,  run_n;
  logic             sat_q,  sat_n;
  logic             zero_q, zero_n;
  logic             rdy_q,  rdy_n;
  logic             en;
  logic [REM_W-1:0] sh, diff;
  logic             ge;

  always_comb begin
    sh   = {rem_q[DEN_W-1:0], 1'b0};
    ge   = sh >= {1'b0, den_q};
    diff = sh - {1'b0, den_q};

    den_n  = den_q;
    rem_n  = rem_q;
    q_n    = q_q;
    quo_n  = quo_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    sat_n  = sat_q;
    zero_n = zero_q;
    rdy_n  = 1'b0;
    if (go) begin
      den_n  = den;
      zero_n = (den == '0);
      sat_n  = (num >= NUM_W'(den));
      rem_n  = (num >= NUM_W'(den)) ? '0 : REM_W'(num);
      q_n    = '0;
      cnt_n  = CNT_W'(Q_W - 1);
      run_n  = 1'b1;
    end else if (run_q) begin
      rem_n = ge ? diff : sh;
      q_n   = {q_q[Q_W-2:0], ge};
      if (cnt_q == '0) begin
        run_n = 1'b0;
        rdy_n = 1'b1;
        if (zero_q)     quo_n = '0;
        else if (sat_q) quo_n = '1;
        else            quo_n = {q_q[Q_W-2:0], ge};
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  assign en = go | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      sat_q  <= 1'b0;
      zero_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_n;
      if (en) begin
        den_q  <= den_n;
        rem_q  <= rem_n;
        q_q    <= q_n;
        quo_q  <= quo_n;
        cnt_q  <= cnt_n;
        run_q  <= run_n;
        sat_q  <= sat_n;
        zero_q <= zero_n;
      end
    end
  end

  assign quo = quo_q;
  assign rdy = rdy_q;
endmodule

// File: rtl/hog_blknorm.sv
module hog_blknorm
  import hnorm_pkg::*;
#(
  parameter int BIN_W    = 14,
  parameter int ENERGY_W = 26,
  parameter int FRAC_W   = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [NCELLS*NBINS*BIN_W-1:0] hist,
  output logic                          busy,
  output logic                          done,
  output logic [NBLK*NBINS*FRAC_W-1:0]  feat
);
  localparam int ROOT_W = ENERGY_W / 2;
  localparam int CBIN_W = NBINS * BIN_W;
  localparam int SLOT_W = NBINS * FRAC_W;
  localparam int FEAT_W = NBLK * SLOT_W;

  logic [1:0] rsync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_sync = rsync_q[1];

  hn_state_e                 st_q, st_n;
  logic [BLK_W-1:0]          blk_q, blk_n;
  logic [NBLK*ENERGY_W-1:0]  eng_q, eng_n, eng_c;
  logic [CBIN_W-1:0]         ctr_q, ctr_n;
  logic [FEAT_W-1:0]         feat_q, feat_n;
  logic                      done_q, done_n;
  logic                      sq_go, sq_rdy, dv_go, dv_all;
  logic [ROOT_W-1:0]         root;
  logic [SLOT_W-1:0]         quo_flat;
  logic [NBINS-1:0]          dv_rdy_v;

  hogn_energy #(.BIN_W(BIN_W), .ENERGY_W(ENERGY_W)) u_energy (
    .hist   (hist),
    .energy (eng_c)
  );

  hogn_isqrt #(.IN_W(ENERGY_W)) u_sqrt (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .go    (sq_go),
    .rad   (eng_q[blk_q*ENERGY_W +: ENERGY_W]),
    .root  (root),
    .rdy   (sq_rdy)
  );

  for (genvar b = 0; b < NBINS; b++) begin : g_div
    hogn_fdiv #(.NUM_W(BIN_W), .DEN_W(ROOT_W), .Q_W(FRAC_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .go    (dv_go),
      .num   (ctr_q[b*BIN_W +: BIN_W]),
      .den   (root),
      .quo   (quo_flat[b*FRAC_W +: FRAC_W]),
      .rdy   (dv_rdy_v[b])
    );
  end

  assign dv_all = &dv_rdy_v;

  always_comb begin
    st_n   = st_q;
    blk_n  = blk_q;
    eng_n  = eng_q;
    ctr_n  = ctr_q;
    feat_n = feat_q;
    done_n = 1'b0;
    sq_go  = 1'b0;
    dv_go  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        eng_n = eng_c;
        ctr_n = hist[CTR*CBIN_W +: CBIN_W];
        blk_n = '0;
        st_n  = ST_LOAD;
      end
      ST_LOAD: begin
        sq_go = 1'b1;
        st_n  = ST_ROOT;
      end
      ST_ROOT: if (sq_rdy) begin
        dv_go = 1'b1;
        st_n  = ST_DIV;
      end
      ST_DIV: if (dv_all) begin
        for (int g = 0; g < NBLK; g++)
          if (blk_q == BLK_W'(g)) feat_n[g*SLOT_W +: SLOT_W] = quo_flat;
        if (blk_q == BLK_W'(NBLK - 1)) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          blk_n = blk_q + 1'b1;
          st_n  = ST_LOAD;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      st_q   <= ST_IDLE;
      blk_q  <= '0;
      eng_q  <= '0;
      ctr_q  <= '0;
      feat_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      blk_q  <= blk_n;
      done_q <= done_n;
      if (st_q == ST_IDLE) begin
        eng_q <= eng_n;
        ctr_q <= ctr_n;
      end
      if (st_q == ST_DIV) feat_q <= feat_n;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign feat = feat_q;
endmodule

// File: rtl/hogn_chk.sv
module hogn_chk #(
  parameter int FEAT_W = 324
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [FEAT_W-1:0] feat
);
  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  feat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(feat));

  // R10
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind hog_blknorm hogn_chk #(.FEAT_W(FEAT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n_sync),
  .start (start),
  .busy  (busy),
  .done  (done),
  .feat  (feat)
);

// File: tb/hog_blknorm_bench.sv
module hog_blknorm_bench;
  localparam int CLK_P = 10;
  localparam int NC = 9, NB = 9, BW = 14, FW = 9;
  localparam longint EMAX = (64'd1 << 26) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NC*NB*BW-1:0] hist = '0;
  logic busy, done;
  logic [4*NB*FW-1:0] feat;

  int hv [NC][NB];
  int expv [36];
  string subt [36];
  int total = 0, bad = 0;
  bit finished = 0;

  hog_blknorm u_hog_blknorm (
    .clk(clk), .rst_n(rst_n), .start(start), .hist(hist),
    .busy(busy), .done(done), .feat(feat)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic longint isqrt_f(input longint e);
    longint lo = 0, hi = 8192;
    while (hi - lo > 1) begin
      longint m = (lo + hi) / 2;
      if (m * m <= e) lo = m; else hi = m;
    end
    return lo;
  endfunction

  task automatic compute_exp();
    for (int g = 0; g < 4; g++) begin
      longint e = 0, n;
      for (int dr = 0; dr < 2; dr++)
        for (int dc = 0; dc < 2; dc++)
          for (int b = 0; b < NB; b++) begin
            longint v = hv[(g/2+dr)*3 + g%2 + dc][b];
            e += v * v;
          end
      if (e > EMAX) e = EMAX;
      n = isqrt_f(e);
      for (int b = 0; b < NB; b++) begin
        longint x = hv[4][b];
        if (n == 0)       begin expv[g*NB+b] = 0;   subt[g*NB+b] = "R7"; end
        else if (x >= n)  begin expv[g*NB+b] = 511; subt[g*NB+b] = "R6"; end
        else begin expv[g*NB+b] = int'((x * 512) / n); subt[g*NB+b] = "R5"; end
      end
    end
  endtask

  function automatic logic [NC*NB*BW-1:0] pack();
    logic [NC*NB*BW-1:0] p;
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++)
        p[(c*NB+b)*BW +: BW] = BW'(hv[c][b]);
    return p;
  endfunction

  task automatic clear_hv();
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) hv[c][b] = 0;
  endtask

  task automatic check1(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    hist = pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 500; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
    if (!ok) begin
      total++; bad++;
      $display("FAIL R9 actual=no_done expected=done");
    end
  endtask

  task automatic compare_feat(input string tag);
    for (int i = 0; i < 36; i++) begin
      string t;
      t = $sformatf("%s/%s/R8 grp%0d bin%0d", tag, subt[i], i / NB, i % NB);
      check1(t, feat[i*FW +: FW], expv[i]);
    end
  endtask

  task automatic run_case(input string tag);
    bit ok;
    compute_exp();
    pulse_start();
    check1("R1 busy after start", busy, 1);
    wait_done(ok);
    if (ok) begin
      check1("R9 busy low at done", busy, 0);
      compare_feat(tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    void'($urandom(32'd20240607));
    clear_hv();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check1("R1 busy reset", busy, 0);
    check1("R1 done reset", done, 0);
    check1("R1 feat reset", (feat == '0), 1);

    // R7: all zero neighbourhood
    clear_hv();
    run_case("R7 zero");

    // R6: lone centre bin equals norm
    clear_hv(); hv[4][0] = 1000;
    run_case("R6 lone");

    // R4: energy 15 -> truncated root 3
    clear_hv(); hv[4][0] = 3; hv[4][1] = 2; hv[4][2] = 1; hv[4][3] = 1;
    run_case("R4 trunc");

    // R7 border: top-left group empty, centre bins zero
    clear_hv();
    for (int b = 0; b < NB; b++) begin hv[5][b] = 50 + b; hv[7][b] = 9 * b; hv[8][b] = 700; end
    run_case("R7 border");

    // R2: distinct neighbours, centre nonzero
    clear_hv();
    for (int b = 0; b < NB; b++) hv[4][b] = 40 * (b + 1);
    for (int b = 0; b < NB; b++) hv[0][b] = 900;
    hv[2][3] = 3000; hv[6][5] = 100; hv[8][8] = 5000;
    run_case("R2 layout");

    // R5/R8 random moderate, some cells zeroed as frame border
    for (int n = 0; n < 30; n++) begin
      for (int c = 0; c < NC; c++) begin
        bit empty = ($urandom % 6 == 0) && (c != 4);
        for (int b = 0; b < NB; b++) hv[c][b] = empty ? 0 : int'($urandom % 1024);
      end
      run_case("R5 rand");
    end

    // R3: full-range bins, clamped energy
    for (int n = 0; n < 6; n++) begin
      for (int c = 0; c < NC; c++)
        for (int b = 0; b < NB; b++) hv[c][b] = int'($urandom % 16384);
      run_case("R3 clamp");
    end

    // R9: result held after done while inputs change without start
    begin
      logic [4*NB*FW-1:0] snap;
      bit extra = 0;
      snap = feat;
      for (int c = 0; c < NC; c++)
        for (int b = 0; b < NB; b++) hv[c][b] = int'($urandom % 16384);
      hist = pack();
      repeat (40) begin
        @(negedge clk);
        if (done) extra = 1;
      end
      check1("R9 no extra done", extra, 0);
      check1("R9 feat held", (feat == snap), 1);
    end

    // R10: second start while busy is ignored
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) hv[c][b] = int'($urandom % 800);
    compute_exp();
    pulse_start();
    repeat (5) @(negedge clk);
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) hv[c][b] = int'($urandom % 800) + 1;
    hist = pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) compare_feat("R10 busy start");
    @(negedge clk);
    check1("R10 idle after run", busy, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule